// File: doc/BRIEF.md
# Display Output Quiesce Sequencer

This block takes a running display pipeline down to a quiet state before it is reconfigured or powered down. A single start pulse launches a fixed chain of steps. Each step clears, or for the interrupt mask and DAC power-down sets, a group of control levels. The chain begins at the overlay windows and works down through the outputs, the timing generator and the display FIFO loader. The control levels leave the block as plain outputs, one per enable, so the surrounding display logic can use them directly.

Each step takes one clock. The exception is a drain interval of DRAIN_US microseconds, held between stopping the timing generator and stopping the FIFO loader. Its length in cycles comes from the clock-frequency parameter. After the loader is stopped, the block waits for the graphics engine to be both not busy and command-empty, then pulses `done` for one cycle.

Counting edge 0 as the clock edge that samples an accepted `start`, and D = CLK_MHZ * DRAIN_US, the levels change at these edges:
- edge 1: windows
- edge 2: VGA and video
- edge 3: interrupt mask
- edge 4: genlock and color key
- edge 5: panel and DAC power-down
- edge 6: CRT, hsync, vsync and DAC blank
- edge 7: compression and decompression
- edge 8: timing generator
- edge 8+D: FIFO loader
- edge 9+D at the earliest: `done`

Top module: `qsq_top`

## Requirements
- R1: While `rst` is high and after it is released with no start, every enable output (`ovl_win_en`, `vga_en`, `vid_en`, `genlock_en`, `ckey_en`, `panel_pwr`, `crt_en`, `hsync_en`, `vsync_en`, `dac_blank_en`, `cmp_en`, `dcmp_en`, `tgen_en`, `fifo_ld_en`) is 1, and `dac_pd`, `irq_mask`, `irq_ack` and `done` are 0.
- R2: All overlay window enables go to 0 after edge 1, and `vga_en` and `vid_en` go to 0 after edge 2.
- R3: `irq_mask` goes to 1 after edge 3, and `irq_ack` is high for exactly the one cycle after edge 3. `genlock_en` and `ckey_en` go to 0 after edge 4.
- R4: `panel_pwr` goes to 0 and `dac_pd` goes to 1 after edge 5. `crt_en`, `hsync_en`, `vsync_en` and `dac_blank_en` go to 0 after edge 6.
- R5: `cmp_en` and `dcmp_en` go to 0 after edge 7, and `tgen_en` goes to 0 after edge 8.
- R6: `fifo_ld_en` goes to 0 exactly D = CLK_MHZ*DRAIN_US clock cycles after `tgen_en` falls, that is after edge 8+D.
- R7: `done` rises after the first edge e >= 9+D at which `eng_busy` is 0 and `eng_cmd_empty` is 1. It never rises otherwise.
- R8: `done` is high for exactly one cycle per accepted start.
- R9: A `start` pulse sampled while a sequence is running has no effect on any output level, on the timing above, or on the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the sequence when it is idle |
| eng_busy | input | 1 | Graphics engine has an operation in flight |
| eng_cmd_empty | input | 1 | Graphics engine command buffer is empty |
| ovl_win_en | output | NUM_WIN | Overlay alpha window enables |
| vga_en | output | 1 | VGA path enable |
| vid_en | output | 1 | Video path enable |
| irq_mask | output | 1 | Display interrupt mask (1 = masked) |
| irq_ack | output | 1 | One-cycle clear of pending interrupt status |
| genlock_en | output | 1 | Genlock enable |
| ckey_en | output | 1 | Color-key enable |
| panel_pwr | output | 1 | Flat panel power |
| dac_pd | output | 1 | DAC power-down (1 = powered down) |
| crt_en | output | 1 | CRT output enable |
| hsync_en | output | 1 | Horizontal sync enable |
| vsync_en | output | 1 | Vertical sync enable |
| dac_blank_en | output | 1 | DAC blank enable |
| cmp_en | output | 1 | Compression enable |
| dcmp_en | output | 1 | Decompression enable |
| tgen_en | output | 1 | Timing generator enable |
| fifo_ld_en | output | 1 | Display FIFO loader enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the final idle wait. The drain interval has to expire while the engine is still busy or its command buffer is not yet empty. The two conditions must then clear at different times, so that only their conjunction releases `done`. The bench uses a small drain interval and sweeps a grid of release edges for busy and command-empty, placed separately before, at and after the earliest completion edge. In some runs the bench also pulses `start` in the middle of the drain interval and on the FIFO-stop edge. This shows that the restart is ignored while the timing stays exact.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WIN,
        ST_VID,
        ST_IRQ,
        ST_GLK,
        ST_PNL,
        ST_CRT,
        ST_CMP,
        ST_TGEN,
        ST_DRAIN,
        ST_IDLEWAIT
    } qsq_step_e;

    typedef struct packed {
        logic vga_en;
        logic vid_en;
        logic irq_mask;
        logic genlock_en;
        logic ckey_en;
        logic panel_pwr;
        logic dac_pd;
        logic crt_en;
        logic hsync_en;
        logic vsync_en;
        logic dac_blank_en;
        logic cmp_en;
        logic dcmp_en;
        logic tgen_en;
        logic fifo_ld_en;
    } qsq_ctl_t;

    localparam qsq_ctl_t CTL_RUN = '{
        vga_en: 1'b1, vid_en: 1'b1, irq_mask: 1'b0,
        genlock_en: 1'b1, ckey_en: 1'b1,
        panel_pwr: 1'b1, dac_pd: 1'b0,
        crt_en: 1'b1, hsync_en: 1'b1, vsync_en: 1'b1, dac_blank_en: 1'b1,
        cmp_en: 1'b1, dcmp_en: 1'b1,
        tgen_en: 1'b1, fifo_ld_en: 1'b1
    };

    function automatic int drain_cycles(input int clk_mhz, input int us);
        return clk_mhz * us;
    endfunction

    // Action taken when a step fires; the window step is handled separately.
    function automatic qsq_ctl_t apply_step(input qsq_ctl_t c, input qsq_step_e s);
        qsq_ctl_t n;
        n = c;
        case (s)
            ST_VID: begin
                n.vga_en = 1'b0;
                n.vid_en = 1'b0;
            end
            ST_IRQ:  n.irq_mask = 1'b1;
            ST_GLK: begin
                n.genlock_en = 1'b0;
                n.ckey_en    = 1'b0;
            end
            ST_PNL: begin
                n.panel_pwr = 1'b0;
                n.dac_pd    = 1'b1;
            end
            ST_CRT: begin
                n.crt_en       = 1'b0;
                n.hsync_en     = 1'b0;
                n.vsync_en     = 1'b0;
                n.dac_blank_en = 1'b0;
            end
            ST_CMP: begin
                n.cmp_en  = 1'b0;
                n.dcmp_en = 1'b0;
            end
            ST_TGEN:  n.tgen_en    = 1'b0;
            ST_DRAIN: n.fifo_ld_en = 1'b0;
            default: ;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/qsq_drain_timer.sv
module qsq_drain_timer #(
    parameter int DRAIN_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(DRAIN_CYC + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(DRAIN_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST_VAL) cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == LAST_VAL);
endmodule

// File: rtl/qsq_step_fsm.sv
module qsq_step_fsm
    import qsq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      drain_last,
    input  logic      eng_idle,
    output qsq_step_e step,
    output logic      fire,
    output logic      done
);
    qsq_step_e nxt;

    always_comb begin
        nxt  = step;
        fire = 1'b0;
        case (step)
            ST_IDLE:     if (start) nxt = ST_WIN;
            ST_WIN:      begin fire = 1'b1; nxt = ST_VID;  end
            ST_VID:      begin fire = 1'b1; nxt = ST_IRQ;  end
            ST_IRQ:      begin fire = 1'b1; nxt = ST_GLK;  end
            ST_GLK:      begin fire = 1'b1; nxt = ST_PNL;  end
            ST_PNL:      begin fire = 1'b1; nxt = ST_CRT;  end
            ST_CRT:      begin fire = 1'b1; nxt = ST_CMP;  end
            ST_CMP:      begin fire = 1'b1; nxt = ST_TGEN; end
            ST_TGEN:     begin fire = 1'b1; nxt = ST_DRAIN; end
            ST_DRAIN:    if (drain_last) begin fire = 1'b1; nxt = ST_IDLEWAIT; end
            ST_IDLEWAIT: if (eng_idle) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE;
            done <= 1'b0;
        end else begin
            step <= nxt;
            done <= (step == ST_IDLEWAIT) && eng_idle;
        end
    end
endmodule

// File: rtl/qsq_ctl_regs.sv
module qsq_ctl_regs
    import qsq_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  qsq_step_e          step,
    output logic [NUM_WIN-1:0] win_en,
    output qsq_ctl_t           ctl,
    output logic               irq_ack
);
    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            always_ff @(posedge clk) begin
                if (rst) win_en[w] <= 1'b1;
                else if (fire && step == ST_WIN) win_en[w] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= CTL_RUN;
            irq_ack <= 1'b0;
        end else begin
            if (fire) ctl <= apply_step(ctl, step);
            irq_ack <= fire && (step == ST_IRQ);
        end
    end
endmodule

// File: rtl/qsq_top.sv
module qsq_top
    import qsq_pkg::*;
#(
    parameter int NUM_WIN  = 3,
    parameter int CLK_MHZ  = 100,
    parameter int DRAIN_US = 1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               eng_busy,
    input  logic               eng_cmd_empty,
    output logic [NUM_WIN-1:0] ovl_win_en,
    output logic               vga_en,
    output logic               vid_en,
    output logic               irq_mask,
    output logic               irq_ack,
    output logic               genlock_en,
    output logic               ckey_en,
    output logic               panel_pwr,
    output logic               dac_pd,
    output logic               crt_en,
    output logic               hsync_en,
    output logic               vsync_en,
    output logic               dac_blank_en,
    output logic               cmp_en,
    output logic               dcmp_en,
    output logic               tgen_en,
    output logic               fifo_ld_en,
    output logic               done
);
    localparam int DRAIN_CYC = drain_cycles(CLK_MHZ, DRAIN_US);

    qsq_step_e step;
    logic      fire;
    logic      drain_last;
    logic      eng_idle;
    qsq_ctl_t  ctl;

    assign eng_idle = !eng_busy && eng_cmd_empty;

    qsq_step_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .drain_last (drain_last),
        .eng_idle   (eng_idle),
        .step       (step),
        .fire       (fire),
        .done       (done)
    );

    qsq_drain_timer #(.DRAIN_CYC(DRAIN_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (step == ST_DRAIN),
        .last (drain_last)
    );

    qsq_ctl_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .step    (step),
        .win_en  (ovl_win_en),
        .ctl     (ctl),
        .irq_ack (irq_ack)
    );

    assign vga_en       = ctl.vga_en;
    assign vid_en       = ctl.vid_en;
    assign irq_mask     = ctl.irq_mask;
    assign genlock_en   = ctl.genlock_en;
    assign ckey_en      = ctl.ckey_en;
    assign panel_pwr    = ctl.panel_pwr;
    assign dac_pd       = ctl.dac_pd;
    assign crt_en       = ctl.crt_en;
    assign hsync_en     = ctl.hsync_en;
    assign vsync_en     = ctl.vsync_en;
    assign dac_blank_en = ctl.dac_blank_en;
    assign cmp_en       = ctl.cmp_en;
    assign dcmp_en      = ctl.dcmp_en;
    assign tgen_en      = ctl.tgen_en;
    assign fifo_ld_en   = ctl.fifo_ld_en;
endmodule

// File: rtl/qsq_checker.sv
module qsq_checker #(
    parameter int NUM_WIN  = 3,
    parameter int CLK_MHZ  = 100,
    parameter int DRAIN_US = 1000
) (
    input logic               clk,
    input logic               rst,
    input logic               eng_busy,
    input logic               eng_cmd_empty,
    input logic [NUM_WIN-1:0] ovl_win_en,
    input logic               vid_en,
    input logic               vga_en,
    input logic               irq_mask,
    input logic               genlock_en,
    input logic               ckey_en,
    input logic               panel_pwr,
    input logic               dac_pd,
    input logic               crt_en,
    input logic               cmp_en,
    input logic               dcmp_en,
    input logic               tgen_en,
    input logic               fifo_ld_en,
    input logic               done
);
    localparam int DRAIN_CYC = CLK_MHZ * DRAIN_US;

    int drain_cnt;
    always_ff @(posedge clk) begin
        if (rst) drain_cnt <= 0;
        else if (!tgen_en && fifo_ld_en) drain_cnt <= drain_cnt + 1;
        else drain_cnt <= 0;
    end

    a_r2_win_before_video: assert property (@(posedge clk) disable iff (rst)
        ($fell(vid_en) || $fell(vga_en)) |-> (ovl_win_en == '0));

    a_r3_mask_before_genlock: assert property (@(posedge clk) disable iff (rst)
        ($fell(genlock_en) || $fell(ckey_en)) |-> irq_mask);

    a_r4_power_before_crt: assert property (@(posedge clk) disable iff (rst)
        $fell(crt_en) |-> (!panel_pwr && dac_pd));

    a_r5_cmp_before_tgen: assert property (@(posedge clk) disable iff (rst)
        $fell(tgen_en) |-> (!cmp_en && !dcmp_en));

    a_r6_drain_length: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_ld_en) |-> (drain_cnt == DRAIN_CYC));

    a_r7_done_needs_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(!eng_busy && eng_cmd_empty) && !fifo_ld_en && !tgen_en));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind qsq_top qsq_checker #(
    .NUM_WIN  (NUM_WIN),
    .CLK_MHZ  (CLK_MHZ),
    .DRAIN_US (DRAIN_US)
) u_qsq_checker (
    .clk           (clk),
    .rst           (rst),
    .eng_busy      (eng_busy),
    .eng_cmd_empty (eng_cmd_empty),
    .ovl_win_en    (ovl_win_en),
    .vid_en        (vid_en),
    .vga_en        (vga_en),
    .irq_mask      (irq_mask),
    .genlock_en    (genlock_en),
    .ckey_en       (ckey_en),
    .panel_pwr     (panel_pwr),
    .dac_pd        (dac_pd),
    .crt_en        (crt_en),
    .cmp_en        (cmp_en),
    .dcmp_en       (dcmp_en),
    .tgen_en       (tgen_en),
    .fifo_ld_en    (fifo_ld_en),
    .done          (done)
);

// File: tb/tb_qsq_top.sv
module tb_qsq_top;
    localparam int NUM_WIN  = 3;
    localparam int CLK_MHZ  = 2;
    localparam int DRAIN_US = 6;
    localparam int D        = CLK_MHZ * DRAIN_US;
    localparam int E_MIN    = 9 + D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic eng_busy = 1'b0;
    logic eng_cmd_empty = 1'b1;
    logic [NUM_WIN-1:0] ovl_win_en;
    logic vga_en, vid_en, irq_mask, irq_ack, genlock_en, ckey_en;
    logic panel_pwr, dac_pd, crt_en, hsync_en, vsync_en, dac_blank_en;
    logic cmp_en, dcmp_en, tgen_en, fifo_ld_en, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    qsq_top #(.NUM_WIN(NUM_WIN), .CLK_MHZ(CLK_MHZ), .DRAIN_US(DRAIN_US)) dut (
        .clk(clk), .rst(rst), .start(start), .eng_busy(eng_busy),
        .eng_cmd_empty(eng_cmd_empty), .ovl_win_en(ovl_win_en),
        .vga_en(vga_en), .vid_en(vid_en), .irq_mask(irq_mask), .irq_ack(irq_ack),
        .genlock_en(genlock_en), .ckey_en(ckey_en), .panel_pwr(panel_pwr),
        .dac_pd(dac_pd), .crt_en(crt_en), .hsync_en(hsync_en), .vsync_en(vsync_en),
        .dac_blank_en(dac_blank_en), .cmp_en(cmp_en), .dcmp_en(dcmp_en),
        .tgen_en(tgen_en), .fifo_ld_en(fifo_ld_en), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int run_levels();
        return {ovl_win_en == '1, vga_en, vid_en, !irq_mask, genlock_en, ckey_en,
                panel_pwr, !dac_pd, crt_en, hsync_en, vsync_en, dac_blank_en,
                cmp_en, dcmp_en, tgen_en, fifo_ld_en} == 16'hFFFF;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R1: levels while reset is held
        chk(run_levels() == 1 && !irq_ack && !done, "R1 reset held", run_levels(), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(run_levels() == 1 && !irq_ack && !done, "R1 idle after reset", run_levels(), 1);
    endtask

    // b_rel / e_rel: first edge index at which busy is 0 / cmd_empty is 1
    task automatic run_seq(input int b_rel, input int e_rel, input bit poke);
        int fw = -1, fv = -1, fi = -1, fg = -1, fp = -1, fc = -1, fk = -1;
        int ft = -1, ff = -1, fd = -1, nd = 0, ack_bad = 0, ack_at3 = 0;
        int lim, exp_done;
        exp_done = (b_rel > e_rel) ? b_rel : e_rel;
        if (exp_done < E_MIN) exp_done = E_MIN;
        lim = exp_done + 12;
        do_reset();
        start = 1'b1;
        eng_busy = (0 < b_rel);
        eng_cmd_empty = !(0 < e_rel);
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= lim; j++) begin
            if (fw < 0 && ovl_win_en == '0) fw = j;
            if (fv < 0 && !vga_en && !vid_en) fv = j;
            if (fi < 0 && irq_mask) fi = j;
            if (fg < 0 && !genlock_en && !ckey_en) fg = j;
            if (fp < 0 && !panel_pwr && dac_pd) fp = j;
            if (fc < 0 && !crt_en && !hsync_en && !vsync_en && !dac_blank_en) fc = j;
            if (fk < 0 && !cmp_en && !dcmp_en) fk = j;
            if (ft < 0 && !tgen_en) ft = j;
            if (ff < 0 && !fifo_ld_en) ff = j;
            if (done) begin
                nd++;
                if (fd < 0) fd = j;
            end
            if (irq_ack) begin
                if (j == 3) ack_at3 = 1;
                else ack_bad++;
            end
            eng_busy = (j + 1 < b_rel);
            eng_cmd_empty = !(j + 1 < e_rel);
            start = poke && ((j + 1 == 12) || (j + 1 == 8 + D));
            @(negedge clk);
        end
        start = 1'b0;
        chk(fw == 1, "R2 windows cleared edge", fw, 1);
        chk(fv == 2, "R2 vga/video cleared edge", fv, 2);
        chk(fi == 3, "R3 irq mask edge", fi, 3);
        chk(ack_at3 == 1 && ack_bad == 0, "R3 irq ack pulse", ack_bad, 0);
        chk(fg == 4, "R3 genlock/color-key edge", fg, 4);
        chk(fp == 5, "R4 panel/dac power edge", fp, 5);
        chk(fc == 6, "R4 crt group edge", fc, 6);
        chk(fk == 7, "R5 compression edge", fk, 7);
        chk(ft == 8, "R5 timing generator edge", ft, 8);
        chk(ff == 8 + D, poke ? "R6 R9 fifo edge with restart pokes" : "R6 fifo edge", ff, 8 + D);
        chk(fd == exp_done, poke ? "R7 R9 done edge with restart pokes" : "R7 done edge", fd, exp_done);
        chk(nd == 1, "R8 one done pulse", nd, 1);
    endtask

    initial begin
        int runs = 0;
        int b_list[4];
        int e_list[3];
        b_list = '{0, 3, E_MIN, E_MIN + 4};
        e_list = '{0, E_MIN + 2, E_MIN + 7};
        foreach (b_list[bi]) begin
            foreach (e_list[ei]) begin
                run_seq(b_list[bi], e_list[ei], (runs % 2) == 1);
                runs++;
            end
        end
        run_seq(E_MIN + 1, E_MIN + 1, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule